// File: doc/BRIEF.md
# Dual-Sided Byte Mailbox Bridge

This block joins a microprocessor-style host bus to a peripheral controller through two single-byte mailboxes, one per direction. Each side has an active-low select, active-low read and write strobes and its own 8-bit bidirectional data bus. Both sides see a pair of status flags. The host sees "may send" (`h_tx_empty`) and "byte waiting" (`h_rx_full`). The peripheral sees the complements of those two flags.

The strobes arrive without a clock relationship to the block. A single system clock samples them through multi-stage synchronisers. A write commits its byte when its strobe is released, and a read updates the flags when its strobe is released. The host can wipe both mailboxes with an active-low clear pin. Each side has a sticky active-low fault output. It goes low when that side writes into a full mailbox or reads from an empty one, and it stays low until a clear.

Top module: `byte_mailbox_bridge`

## Requirements
- R1: After system reset, and after `h_clr_n` has been held low, the flags read `h_tx_empty`=1, `h_rx_full`=0, `p_rx_full`=0 and `p_tx_empty`=1. Both fault outputs are high and both mailbox bytes are 8'h00.
- R2: `h_tx_empty` always equals the inverse of `p_rx_full`, and `h_rx_full` always equals the inverse of `p_tx_empty`.
- R3: While `h_sel_n` is high, host read and write strobes have no effect on flags, mailbox contents or faults.
- R4: `h_data` is driven only while `h_sel_n` and `h_rd_n` are both low, and it then carries the peripheral-to-host byte. At all other times it is high impedance. `p_data` behaves the same way with `p_sel_n`, `p_rd_n` and the host-to-peripheral byte.
- R5: A host write with `h_tx_empty` high stores the byte on `h_data` and drops `h_tx_empty` low. The peripheral then reads that byte.
- R6: A peripheral read of a pending host byte returns `h_tx_empty` to high.
- R7: A peripheral write with `p_tx_empty` high sets `h_rx_full`. A host read returns the byte and drops `h_rx_full` low.
- R8: A host write while `h_tx_empty` is low drives `h_fault_n` low and leaves the pending byte unchanged.
- R9: A host read while `h_rx_full` is low drives `h_fault_n` low and returns the last byte the mailbox held.
- R10: A fault output, once low, stays low until a clear.
- R11: The peripheral side follows the same overrun and underrun rules on `p_fault_n`, and its violations leave `h_fault_n` untouched.
- R12: Flags change only in response to a completed strobe or a clear. A flag never moves while both sides are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every strobe |
| rst_n | input | 1 | Asynchronous active-low system reset, released synchronously |
| h_sel_n | input | 1 | Host select, active low |
| h_rd_n | input | 1 | Host read strobe, active low |
| h_wr_n | input | 1 | Host write strobe, active low |
| h_data | inout | 8 | Host data bus |
| h_clr_n | input | 1 | Host clear of both mailboxes and faults, active low |
| h_fault_n | output | 1 | Host-side protocol fault, active low, sticky |
| h_tx_empty | output | 1 | Host may write a byte |
| h_rx_full | output | 1 | A byte waits for the host |
| p_sel_n | input | 1 | Peripheral select, active low |
| p_rd_n | input | 1 | Peripheral read strobe, active low |
| p_wr_n | input | 1 | Peripheral write strobe, active low |
| p_data | inout | 8 | Peripheral data bus |
| p_fault_n | output | 1 | Peripheral-side protocol fault, active low, sticky |
| p_rx_full | output | 1 | A byte from the host waits for the peripheral |
| p_tx_empty | output | 1 | Peripheral may write a byte |

## Verification
The properties assume that every strobe stays low, and then high, for at least three clock periods. They also assume that a side's select does not change while one of its strobes is low, and that write data is stable from the start of the strobe until one period after its release. The directed tasks drive and release every pin on the falling clock edge. Each task holds a strobe for four periods and keeps data for one period past the release, then idles for seven periods. The faults are provoked on purpose only through the overrun and underrun scenarios.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  // Completed-strobe events from one side of the bridge
  typedef struct packed {
    logic rd_done;
    logic wr_done;
  } mbx_evt_t;
endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] stage_d;
      if (s == 0) begin : g_first
        assign stage_d = din;
      end else begin : g_next
        assign stage_d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_d;
      end
    end
  endgenerate

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/mbx_side.sv
module mbx_side
  import mbx_pkg::*;
#(
  parameter int unsigned DW     = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [DW-1:0] bus_in,
  output mbx_evt_t      evt,
  output logic [DW-1:0] wr_byte
);
  logic [1:0]    act_raw, act_s;
  logic [1:0]    act_q;
  logic [DW-1:0] bus_s;
  logic [DW-1:0] hold_q, hold_d;

  // bit 1: read active, bit 0: write active
  assign act_raw = {~sel_n & ~rd_n, ~sel_n & ~wr_n};

  mbx_sync #(.WIDTH(2), .STAGES(STAGES)) i_strobe_sync (
    .clk(clk), .rst_n(rst_n), .din(act_raw), .dout(act_s)
  );

  // Data travels through the same depth so it lines up with the strobe
  mbx_sync #(.WIDTH(DW), .STAGES(STAGES)) i_data_sync (
    .clk(clk), .rst_n(rst_n), .din(bus_in), .dout(bus_s)
  );

  always_comb begin
    hold_d = hold_q;
    if (act_s[0]) hold_d = bus_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= '0;
      hold_q <= '0;
    end else begin
      act_q  <= act_s;
      hold_q <= hold_d;
    end
  end

  assign evt.rd_done = act_q[1] & ~act_s[1];
  assign evt.wr_done = act_q[0] & ~act_s[0];
  assign wr_byte     = hold_q;
endmodule

// File: rtl/mbx_slot.sv
module mbx_slot #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_pulse,
  input  logic [DW-1:0] wr_byte,
  input  logic          rd_pulse,
  output logic          full,
  output logic [DW-1:0] data,
  output logic          overrun,
  output logic          underrun
);
  logic          full_q, full_d;
  logic [DW-1:0] data_q, data_d;

  assign overrun  = wr_pulse & full_q;
  assign underrun = rd_pulse & ~full_q;

  always_comb begin
    full_d = full_q;
    data_d = data_q;
    if (clr) begin
      full_d = 1'b0;
      data_d = '0;
    end else begin
      if (wr_pulse && !full_q) begin
        full_d = 1'b1;
        data_d = wr_byte;
      end
      if (rd_pulse && full_q) full_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      full_q <= full_d;
      data_q <= data_d;
    end
  end

  assign full = full_q;
  assign data = data_q;
endmodule

// File: rtl/byte_mailbox_bridge.sv
module byte_mailbox_bridge
  import mbx_pkg::*;
#(
  parameter int unsigned DW     = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_sel_n,
  input  logic          h_rd_n,
  input  logic          h_wr_n,
  inout  wire  [DW-1:0] h_data,
  input  logic          h_clr_n,
  output logic          h_fault_n,
  output logic          h_tx_empty,
  output logic          h_rx_full,
  input  logic          p_sel_n,
  input  logic          p_rd_n,
  input  logic          p_wr_n,
  inout  wire  [DW-1:0] p_data,
  output logic          p_fault_n,
  output logic          p_rx_full,
  output logic          p_tx_empty
);
  localparam int unsigned RST_STAGES = 2;

  // Reset: asserted asynchronously, released on the clock
  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[RST_STAGES-1];

  logic clr_s, clr;
  mbx_sync #(.WIDTH(1), .STAGES(STAGES)) i_clr_sync (
    .clk(clk), .rst_n(rst_sync_n), .din(~h_clr_n), .dout(clr_s)
  );
  assign clr = clr_s;

  mbx_evt_t      h_evt, p_evt;
  logic [DW-1:0] h_wbyte, p_wbyte;

  mbx_side #(.DW(DW), .STAGES(STAGES)) i_host_side (
    .clk(clk), .rst_n(rst_sync_n), .sel_n(h_sel_n), .rd_n(h_rd_n),
    .wr_n(h_wr_n), .bus_in(h_data), .evt(h_evt), .wr_byte(h_wbyte)
  );

  mbx_side #(.DW(DW), .STAGES(STAGES)) i_periph_side (
    .clk(clk), .rst_n(rst_sync_n), .sel_n(p_sel_n), .rd_n(p_rd_n),
    .wr_n(p_wr_n), .bus_in(p_data), .evt(p_evt), .wr_byte(p_wbyte)
  );

  logic hw_pulse, hr_pulse, pw_pulse, pr_pulse;
  assign hw_pulse = h_evt.wr_done;
  assign hr_pulse = h_evt.rd_done;
  assign pw_pulse = p_evt.wr_done;
  assign pr_pulse = p_evt.rd_done;

  logic          hp_full, hp_ovr, hp_und;
  logic          ph_full, ph_ovr, ph_und;
  logic [DW-1:0] hp_data, ph_data;

  // Host to peripheral mailbox
  mbx_slot #(.DW(DW)) i_slot_h2p (
    .clk(clk), .rst_n(rst_sync_n), .clr(clr),
    .wr_pulse(hw_pulse), .wr_byte(h_wbyte), .rd_pulse(pr_pulse),
    .full(hp_full), .data(hp_data), .overrun(hp_ovr), .underrun(hp_und)
  );

  // Peripheral to host mailbox
  mbx_slot #(.DW(DW)) i_slot_p2h (
    .clk(clk), .rst_n(rst_sync_n), .clr(clr),
    .wr_pulse(pw_pulse), .wr_byte(p_wbyte), .rd_pulse(hr_pulse),
    .full(ph_full), .data(ph_data), .overrun(ph_ovr), .underrun(ph_und)
  );

  // Sticky faults, one per side
  logic h_fault_q, h_fault_d, p_fault_q, p_fault_d;
  always_comb begin
    h_fault_d = h_fault_q | hp_ovr | ph_und;
    p_fault_d = p_fault_q | ph_ovr | hp_und;
    if (clr) begin
      h_fault_d = 1'b0;
      p_fault_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      h_fault_q <= 1'b0;
      p_fault_q <= 1'b0;
    end else begin
      h_fault_q <= h_fault_d;
      p_fault_q <= p_fault_d;
    end
  end

  assign h_fault_n  = ~h_fault_q;
  assign p_fault_n  = ~p_fault_q;
  assign h_tx_empty = ~hp_full;
  assign p_rx_full  = hp_full;
  assign h_rx_full  = ph_full;
  assign p_tx_empty = ~ph_full;

  assign h_data = (!h_sel_n && !h_rd_n) ? ph_data : {DW{1'bz}};
  assign p_data = (!p_sel_n && !p_rd_n) ? hp_data : {DW{1'bz}};
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker (
  input logic clk,
  input logic rst_n,
  input logic clr,
  input logic hw_pulse,
  input logic hr_pulse,
  input logic pw_pulse,
  input logic pr_pulse,
  input logic h_tx_empty,
  input logic h_rx_full,
  input logic h_fault_n,
  input logic p_fault_n
);
  a_r1_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (h_tx_empty && !h_rx_full && h_fault_n && p_fault_n));

  a_r5_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_pulse && h_tx_empty && !clr) |=> !h_tx_empty);

  a_r6_read_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (pr_pulse && !h_tx_empty && !clr) |=> h_tx_empty);

  a_r7_host_read_drains: assert property (@(posedge clk) disable iff (!rst_n)
    (hr_pulse && h_rx_full && !clr) |=> !h_rx_full);

  a_r8_overrun_faults: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_pulse && !h_tx_empty && !clr) |=> !h_fault_n);

  a_r9_underrun_faults: assert property (@(posedge clk) disable iff (!rst_n)
    (hr_pulse && !h_rx_full && !clr) |=> !h_fault_n);

  a_r10_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!h_fault_n && !clr) |=> !h_fault_n);

  a_r11_periph_underrun: assert property (@(posedge clk) disable iff (!rst_n)
    (pr_pulse && h_tx_empty && !clr) |=> !p_fault_n);

  a_r12_quiet_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !hw_pulse && !hr_pulse && !pw_pulse && !pr_pulse)
      |=> ($stable(h_tx_empty) && $stable(h_rx_full)));
endmodule

bind byte_mailbox_bridge mbx_checker i_mbx_checker (
  .clk(clk), .rst_n(rst_sync_n), .clr(clr),
  .hw_pulse(hw_pulse), .hr_pulse(hr_pulse),
  .pw_pulse(pw_pulse), .pr_pulse(pr_pulse),
  .h_tx_empty(h_tx_empty), .h_rx_full(h_rx_full),
  .h_fault_n(h_fault_n), .p_fault_n(p_fault_n)
);

// File: tb/test_byte_mailbox_bridge.sv
module test_byte_mailbox_bridge;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic h_sel_n = 1'b1, h_rd_n = 1'b1, h_wr_n = 1'b1, h_clr_n = 1'b1;
  logic p_sel_n = 1'b1, p_rd_n = 1'b1, p_wr_n = 1'b1;
  logic h_en = 1'b0, p_en = 1'b0;
  logic [7:0] h_drv = 8'h00, p_drv = 8'h00;
  wire  [7:0] h_data, p_data;
  logic h_fault_n, h_tx_empty, h_rx_full, p_fault_n, p_rx_full, p_tx_empty;
  int n_chk = 0, n_fail = 0;
  logic [7:0] rd_val;

  always #10 clk = ~clk;

  assign h_data = h_en ? h_drv : 8'hzz;
  assign p_data = p_en ? p_drv : 8'hzz;

  byte_mailbox_bridge i_byte_mailbox_bridge (
    .clk(clk), .rst_n(rst_n),
    .h_sel_n(h_sel_n), .h_rd_n(h_rd_n), .h_wr_n(h_wr_n), .h_data(h_data),
    .h_clr_n(h_clr_n), .h_fault_n(h_fault_n), .h_tx_empty(h_tx_empty),
    .h_rx_full(h_rx_full),
    .p_sel_n(p_sel_n), .p_rd_n(p_rd_n), .p_wr_n(p_wr_n), .p_data(p_data),
    .p_fault_n(p_fault_n), .p_rx_full(p_rx_full), .p_tx_empty(p_tx_empty)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // flags packed as {h_tx_empty, h_rx_full, p_rx_full, p_tx_empty}
  task automatic chk_flags(input string req, input logic [3:0] exp);
    chk(req, {4'h0, h_tx_empty, h_rx_full, p_rx_full, p_tx_empty}, {4'h0, exp});
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_write(input logic [7:0] b, input logic sel_n);
    @(negedge clk); h_drv = b; h_en = 1'b1; h_sel_n = sel_n; h_wr_n = 1'b0;
    idle(4); h_wr_n = 1'b1; h_sel_n = 1'b1;
    idle(1); h_en = 1'b0;
    idle(7);
  endtask

  task automatic periph_write(input logic [7:0] b);
    @(negedge clk); p_drv = b; p_en = 1'b1; p_sel_n = 1'b0; p_wr_n = 1'b0;
    idle(4); p_wr_n = 1'b1; p_sel_n = 1'b1;
    idle(1); p_en = 1'b0;
    idle(7);
  endtask

  task automatic host_read(output logic [7:0] b);
    @(negedge clk); h_sel_n = 1'b0; h_rd_n = 1'b0;
    idle(4); b = h_data; h_rd_n = 1'b1; h_sel_n = 1'b1;
    idle(8);
  endtask

  task automatic periph_read(output logic [7:0] b);
    @(negedge clk); p_sel_n = 1'b0; p_rd_n = 1'b0;
    idle(4); b = p_data; p_rd_n = 1'b1; p_sel_n = 1'b1;
    idle(8);
  endtask

  task automatic do_clear();
    @(negedge clk); h_clr_n = 1'b0;
    idle(4); h_clr_n = 1'b1;
    idle(4);
  endtask

  task automatic t_reset();
    chk_flags("R1 reset flags", 4'b1001);
    chk("R1 reset h_fault_n", {7'h0, h_fault_n}, 8'h01);
    chk("R1 reset p_fault_n", {7'h0, p_fault_n}, 8'h01);
    chk("R4 idle host bus z", h_data, 8'hzz);
    chk("R4 idle periph bus z", p_data, 8'hzz);
  endtask

  task automatic t_deselected();
    host_write(8'h77, 1'b1);
    chk_flags("R3 deselected write ignored", 4'b1001);
    chk("R3 no fault", {7'h0, h_fault_n}, 8'h01);
    @(negedge clk); h_sel_n = 1'b1; h_rd_n = 1'b0;
    idle(2);
    chk("R4 bus z while deselected read", h_data, 8'hzz);
    h_rd_n = 1'b1;
    idle(7);
    chk_flags("R3 deselected read ignored", 4'b1001);
    chk("R3 deselected read no fault", {7'h0, h_fault_n}, 8'h01);
  endtask

  task automatic t_host_to_periph();
    host_write(8'hA5, 1'b0);
    chk_flags("R5 R2 host write flags", 4'b0011);
    idle(20);
    chk_flags("R12 flags hold while idle", 4'b0011);
    periph_read(rd_val);
    chk("R5 periph reads host byte", rd_val, 8'hA5);
    chk_flags("R6 periph read frees", 4'b1001);
    chk("R6 no fault", {6'h0, h_fault_n, p_fault_n}, 8'h03);
  endtask

  task automatic t_periph_to_host();
    periph_write(8'h3C);
    chk_flags("R7 R2 periph write flags", 4'b1100);
    host_read(rd_val);
    chk("R7 host reads periph byte", rd_val, 8'h3C);
    chk_flags("R7 host read drains", 4'b1001);
  endtask

  task automatic t_underrun();
    host_read(rd_val);
    chk("R9 underrun returns last byte", rd_val, 8'h3C);
    chk("R9 underrun faults host", {7'h0, h_fault_n}, 8'h00);
    chk("R11 host fault leaves p_fault_n", {7'h0, p_fault_n}, 8'h01);
    idle(30);
    chk("R10 fault sticky", {7'h0, h_fault_n}, 8'h00);
    do_clear();
    chk("R10 clear releases fault", {7'h0, h_fault_n}, 8'h01);
  endtask

  task automatic t_overrun();
    host_write(8'h11, 1'b0);
    chk("R8 first write no fault", {7'h0, h_fault_n}, 8'h01);
    host_write(8'h22, 1'b0);
    chk("R8 overrun faults host", {7'h0, h_fault_n}, 8'h00);
    chk_flags("R8 still one byte pending", 4'b0011);
    periph_read(rd_val);
    chk("R8 pending byte kept", rd_val, 8'h11);
    do_clear();
  endtask

  task automatic t_clear_mid();
    periph_write(8'h5A);
    host_write(8'h6B, 1'b0);
    chk_flags("R1 both full before clear", 4'b0110);
    do_clear();
    chk_flags("R1 clear flags", 4'b1001);
    host_read(rd_val);
    chk("R1 clear zeroes byte", rd_val, 8'h00);
    do_clear();
  endtask

  task automatic t_periph_faults();
    periph_read(rd_val);
    chk("R11 periph underrun faults", {6'h0, h_fault_n, p_fault_n}, 8'h02);
    chk("R11 periph underrun byte", rd_val, 8'h00);
    do_clear();
    periph_write(8'h81);
    periph_write(8'h82);
    chk("R11 periph overrun faults", {6'h0, h_fault_n, p_fault_n}, 8'h02);
    host_read(rd_val);
    chk("R11 periph pending byte kept", rd_val, 8'h81);
    do_clear();
    chk("R1 faults idle after clear", {6'h0, h_fault_n, p_fault_n}, 8'h03);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_deselected();
    t_host_to_periph();
    t_periph_to_host();
    t_underrun();
    t_overrun();
    t_clear_mid();
    t_periph_faults();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule